// File: doc/BRIEF.md
# Dual-Port Token Flags

A bank of single-bit token flags shared by two processors, each on its own independent port (left and right). The bank is separate from any data storage and is reached through a per-port token select, not through the memory enable. A processor claims a token by writing a 0 to a flag. It then reads the flag to learn whether it holds the token, and it gives the token back by writing a 1.

The flags do not guard any resource in hardware, and they never hold up either port. Ownership is kept exclusive: at most one port holds a flag. A request for a flag that the other side holds is remembered as pending. When the holder releases the flag, the waiting port takes it over by itself. When both ports claim the same free flag in the same cycle, the left port wins and the right port's claim becomes pending.

Each port also reports standby when neither its memory enable nor its token select is active.

Top module: `dpsem_bank`

## Requirements
- R1: After reset every flag is free and no request is pending, so both ports read 1 from every flag.
- R2: A port writes by asserting its token select and its write strobe with a flag index; write data 0 is a request and write data 1 is a release. A request to a free flag makes that port the holder from the next cycle.
- R3: Reading is combinational and has no wait: with the select high and the write strobe low, the read bit is 0 for the holding port and 1 for any other port. With the select low, the read bit is 1.
- R4: The two ports never both read 0 from the same flag.
- R5: A request to a flag that the other port holds is kept pending. When the holder releases the flag, the waiting port is the holder from the next cycle.
- R6: When both ports request the same free flag in the same cycle, the left port becomes the holder and the right request is kept pending.
- R7: A release written by a port that does not hold the flag clears only that port's own pending request and leaves the holder unchanged.
- R8: A release by the holder, with no pending request from the other port, leaves the flag free.
- R9: Writes with the token select low, and selected cycles with the write strobe low, change no flag. A write to one flag leaves every other flag unchanged.
- R10: A port's standby output is 1 exactly when both its memory enable and its token select are low.
- R11: When the holder releases a flag in the same cycle that the other port requests it, the other port is the holder from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_mem_en | input | 1 | Left memory enable (used only for standby) |
| l_sem_sel | input | 1 | Left token select |
| l_idx | input | 3 | Left flag index |
| l_wr | input | 1 | Left write strobe |
| l_wdata | input | 1 | Left write bit (0 request, 1 release) |
| l_rdata | output | 1 | Left read bit (0 when left holds the flag) |
| l_standby | output | 1 | Left standby indication |
| r_mem_en | input | 1 | Right memory enable (used only for standby) |
| r_sem_sel | input | 1 | Right token select |
| r_idx | input | 3 | Right flag index |
| r_wr | input | 1 | Right write strobe |
| r_wdata | input | 1 | Right write bit (0 request, 1 release) |
| r_rdata | output | 1 | Right read bit (0 when right holds the flag) |
| r_standby | output | 1 | Right standby indication |

## Verification
The two events that can fall in the same cycle are writes from both ports to one flag. The first case is two requests to a free flag, which the left must win while the right's claim stays pending. The second case is a release by the holder together with a request from the other side, which must hand the flag straight over. The bench drives both strobes on the same clock edge to the same index and then reads that flag from both ports in the following cycle. It judges the outcome by which port reads 0. The pending state left behind is then judged by releasing the flag and checking who takes it next.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } own_e;

   typedef struct packed {
      logic req;
      logic rel;
   } port_op_t;
endpackage

// File: rtl/dpsem_port_dec.sv
module dpsem_port_dec #(
   parameter int NUM_FLAGS = 8,
   localparam int IDX_W = $clog2(NUM_FLAGS)
) (
   input  logic                 sel,
   input  logic                 wr,
   input  logic                 wdata,
   input  logic [IDX_W-1:0]     idx,
   output dpsem_pkg::port_op_t  op [NUM_FLAGS]
);
   logic active;
   assign active = sel & wr;

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_dec
      logic hit;
      assign hit        = active && (idx == IDX_W'(g));
      assign op[g].req  = hit & ~wdata;
      assign op[g].rel  = hit &  wdata;
   end
endmodule

// File: rtl/dpsem_cell.sv
module dpsem_cell #(
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  dpsem_pkg::port_op_t l_op,
   input  dpsem_pkg::port_op_t r_op,
   output logic                own_l,
   output logic                own_r,
   output logic                pend_l,
   output logic                pend_r
);
   import dpsem_pkg::*;

   own_e own_q, own_d;
   logic pl_q, pl_d, pr_q, pr_d;
   logic tie_to_left;

   if (TIE_LEFT) begin : g_tie_l
      assign tie_to_left = l_op.req;
   end else begin : g_tie_r
      assign tie_to_left = l_op.req & ~r_op.req;
   end

   always_comb begin
      own_d = own_q;
      pl_d  = pl_q;
      pr_d  = pr_q;
      unique case (own_q)
         OWN_NONE: begin
            pl_d = 1'b0;
            pr_d = 1'b0;
            if (tie_to_left) begin
               own_d = OWN_LEFT;
               pr_d  = r_op.req;
            end else if (r_op.req) begin
               own_d = OWN_RIGHT;
               pl_d  = l_op.req;
            end
         end
         OWN_LEFT: begin
            pl_d = 1'b0;
            if (r_op.rel) pr_d = 1'b0;
            if (r_op.req) pr_d = 1'b1;
            if (l_op.rel) begin
               if (pr_d) begin
                  own_d = OWN_RIGHT;
                  pr_d  = 1'b0;
               end else begin
                  own_d = OWN_NONE;
               end
            end
         end
         OWN_RIGHT: begin
            pr_d = 1'b0;
            if (l_op.rel) pl_d = 1'b0;
            if (l_op.req) pl_d = 1'b1;
            if (r_op.rel) begin
               if (pl_d) begin
                  own_d = OWN_LEFT;
                  pl_d  = 1'b0;
               end else begin
                  own_d = OWN_NONE;
               end
            end
         end
         default: begin
            own_d = OWN_NONE;
            pl_d  = 1'b0;
            pr_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_q <= OWN_NONE;
         pl_q  <= 1'b0;
         pr_q  <= 1'b0;
      end else begin
         own_q <= own_d;
         pl_q  <= pl_d;
         pr_q  <= pr_d;
      end
   end

   assign own_l  = (own_q == OWN_LEFT);
   assign own_r  = (own_q == OWN_RIGHT);
   assign pend_l = pl_q;
   assign pend_r = pr_q;
endmodule

// File: rtl/dpsem_rd_mux.sv
module dpsem_rd_mux #(
   parameter int NUM_FLAGS = 8,
   localparam int IDX_W = $clog2(NUM_FLAGS)
) (
   input  logic                 sel,
   input  logic [IDX_W-1:0]     idx,
   input  logic [NUM_FLAGS-1:0] own,
   output logic                 rdata
);
   assign rdata = sel ? ~own[idx] : 1'b1;
endmodule

// File: rtl/dpsem_bank.sv
module dpsem_bank #(
   parameter int NUM_FLAGS = 8,
   parameter bit TIE_LEFT  = 1'b1,
   localparam int IDX_W = $clog2(NUM_FLAGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             l_mem_en,
   input  logic             l_sem_sel,
   input  logic [IDX_W-1:0] l_idx,
   input  logic             l_wr,
   input  logic             l_wdata,
   output logic             l_rdata,
   output logic             l_standby,
   input  logic             r_mem_en,
   input  logic             r_sem_sel,
   input  logic [IDX_W-1:0] r_idx,
   input  logic             r_wr,
   input  logic             r_wdata,
   output logic             r_rdata,
   output logic             r_standby
);
   import dpsem_pkg::*;

   if (NUM_FLAGS < 2) begin : g_bad_count
      $error("dpsem_bank: NUM_FLAGS must be at least 2");
   end
   if ((1 << IDX_W) != NUM_FLAGS) begin : g_bad_pow2
      $error("dpsem_bank: NUM_FLAGS must be a power of two");
   end

   port_op_t             l_op [NUM_FLAGS];
   port_op_t             r_op [NUM_FLAGS];
   logic [NUM_FLAGS-1:0] own_l, own_r, pend_l, pend_r;

   dpsem_port_dec #(.NUM_FLAGS(NUM_FLAGS)) i_dec_l (
      .sel(l_sem_sel), .wr(l_wr), .wdata(l_wdata), .idx(l_idx), .op(l_op)
   );
   dpsem_port_dec #(.NUM_FLAGS(NUM_FLAGS)) i_dec_r (
      .sel(r_sem_sel), .wr(r_wr), .wdata(r_wdata), .idx(r_idx), .op(r_op)
   );

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cell
      dpsem_cell #(.TIE_LEFT(TIE_LEFT)) i_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .l_op   (l_op[g]),
         .r_op   (r_op[g]),
         .own_l  (own_l[g]),
         .own_r  (own_r[g]),
         .pend_l (pend_l[g]),
         .pend_r (pend_r[g])
      );
   end

   dpsem_rd_mux #(.NUM_FLAGS(NUM_FLAGS)) i_rd_l (
      .sel(l_sem_sel & ~l_wr), .idx(l_idx), .own(own_l), .rdata(l_rdata)
   );
   dpsem_rd_mux #(.NUM_FLAGS(NUM_FLAGS)) i_rd_r (
      .sel(r_sem_sel & ~r_wr), .idx(r_idx), .own(own_r), .rdata(r_rdata)
   );

   assign l_standby = ~(l_mem_en | l_sem_sel);
   assign r_standby = ~(r_mem_en | r_sem_sel);
endmodule

// File: rtl/dpsem_chk.sv
module dpsem_chk #(
   parameter int NUM_FLAGS = 8,
   localparam int IDX_W = $clog2(NUM_FLAGS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 l_sem_sel,
   input logic [IDX_W-1:0]     l_idx,
   input logic                 l_wr,
   input logic                 l_wdata,
   input logic                 l_rdata,
   input logic                 r_sem_sel,
   input logic [IDX_W-1:0]     r_idx,
   input logic                 r_wr,
   input logic                 r_wdata,
   input logic                 r_rdata,
   input logic [NUM_FLAGS-1:0] own_l,
   input logic [NUM_FLAGS-1:0] own_r,
   input logic [NUM_FLAGS-1:0] pend_r
);
   logic l_req, l_rel, r_req, r_rel;
   assign l_req = l_sem_sel && l_wr && !l_wdata;
   assign l_rel = l_sem_sel && l_wr &&  l_wdata;
   assign r_req = r_sem_sel && r_wr && !r_wdata;
   assign r_rel = r_sem_sel && r_wr &&  r_wdata;

   a_r4_not_both_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sem_sel && !l_wr && r_sem_sel && !r_wr && l_idx == r_idx)
         |-> !(!l_rdata && !r_rdata));

   a_r3_holder_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (l_sem_sel && !l_wr && own_l[l_idx]) |-> !l_rdata);

   a_r2_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
      (l_req && !own_l[l_idx] && !own_r[l_idx]) |=> own_l[$past(l_idx)]);

   a_r5_handoff: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rel && own_l[l_idx] && pend_r[l_idx]) |=> own_r[$past(l_idx)]);

   a_r8_release_free: assert property (@(posedge clk) disable iff (!rst_n)
      (l_rel && own_l[l_idx] && !pend_r[l_idx] && !(r_req && r_idx == l_idx))
         |=> (!own_l[$past(l_idx)] && !own_r[$past(l_idx)]));

   a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_req && !l_rel && !r_req && !r_rel)
         |=> ($stable(own_l) && $stable(own_r) && $stable(pend_r)));
endmodule

bind dpsem_bank dpsem_chk #(.NUM_FLAGS(NUM_FLAGS)) i_chk (
   .clk(clk), .rst_n(rst_n),
   .l_sem_sel(l_sem_sel), .l_idx(l_idx), .l_wr(l_wr), .l_wdata(l_wdata), .l_rdata(l_rdata),
   .r_sem_sel(r_sem_sel), .r_idx(r_idx), .r_wr(r_wr), .r_wdata(r_wdata), .r_rdata(r_rdata),
   .own_l(own_l), .own_r(own_r), .pend_r(pend_r)
);

// File: tb/test_dpsem_bank.sv
module test_dpsem_bank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       l_mem_en = 0, l_sem_sel = 0, l_wr = 0, l_wdata = 1;
   logic       r_mem_en = 0, r_sem_sel = 0, r_wr = 0, r_wdata = 1;
   logic [2:0] l_idx = 0, r_idx = 0;
   logic       l_rdata, l_standby, r_rdata, r_standby;
   int         total = 0, bad = 0;

   always #5 clk = ~clk;

   dpsem_bank i_dpsem_bank (.*);

   // vector: {lsel,lwr,ld,lidx[3], rsel,rwr,rd,ridx[3], chk_idx[3], exp_l, exp_r}
   localparam int NV = 15;
   localparam logic [16:0] VEC [NV] = '{
      {3'b110,3'd2, 3'b000,3'd0, 3'd2, 2'b01},  // L request 2
      {3'b000,3'd0, 3'b110,3'd2, 3'd2, 2'b01},  // R request 2 -> pending
      {3'b111,3'd2, 3'b000,3'd0, 3'd2, 2'b10},  // L release 2 -> R takes
      {3'b000,3'd0, 3'b111,3'd2, 3'd2, 2'b11},  // R release 2 -> free
      {3'b110,3'd5, 3'b110,3'd5, 3'd5, 2'b01},  // both request 5 -> left
      {3'b111,3'd5, 3'b000,3'd0, 3'd5, 2'b10},  // L release -> pending R takes
      {3'b110,3'd5, 3'b000,3'd0, 3'd5, 2'b10},  // L request -> pending
      {3'b111,3'd5, 3'b000,3'd0, 3'd5, 2'b10},  // L non-owner release clears pend
      {3'b000,3'd0, 3'b111,3'd5, 3'd5, 2'b11},  // R release -> free, no handoff
      {3'b000,3'd0, 3'b110,3'd0, 3'd0, 2'b10},  // R request 0
      {3'b010,3'd1, 3'b000,3'd0, 3'd1, 2'b11},  // unselected write ignored
      {3'b100,3'd1, 3'b000,3'd0, 3'd1, 2'b11},  // selected no strobe ignored
      {3'b110,3'd7, 3'b000,3'd0, 3'd0, 2'b10},  // write 7 leaves 0 alone
      {3'b110,3'd0, 3'b111,3'd0, 3'd0, 2'b01},  // R release + L request same cycle
      {3'b000,3'd0, 3'b000,3'd0, 3'd7, 2'b01}   // flag 7 held by L
   };
   localparam string VTAG [NV] = '{"R2","R5","R5","R8","R6","R6","R5","R7","R7",
                                   "R2","R9","R9","R9","R11","R9"};

   task automatic check(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic drive(input logic ls, lw, ld, input logic [2:0] li,
                        input logic rs, rw, rd, input logic [2:0] ri);
      @(negedge clk);
      l_sem_sel = ls; l_wr = lw; l_wdata = ld; l_idx = li;
      r_sem_sel = rs; r_wr = rw; r_wdata = rd; r_idx = ri;
   endtask

   task automatic read_both(input logic [2:0] i, input string tag,
                            input logic el, input logic er);
      drive(1, 0, 1, i, 1, 0, 1, i);
      #1;
      check({tag, " left"}, l_rdata, el);
      check({tag, " right"}, r_rdata, er);
   endtask

   task automatic read_all_free(input string tag);
      for (int i = 0; i < 8; i++) read_both(3'(i), tag, 1'b1, 1'b1);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, every flag free on both ports
      read_all_free("R1");

      for (int v = 0; v < NV; v++) begin
         logic [16:0] e;
         e = VEC[v];
         drive(e[16], e[15], e[14], e[13:11], e[10], e[9], e[8], e[7:5]);
         read_both(e[4:2], VTAG[v], e[1], e[0]);
      end

      // R3: unselected read returns 1 even for holder of flag 7 (left)
      drive(0, 0, 1, 3'd7, 0, 0, 1, 3'd7);
      #1;
      check("R3 unselected left", l_rdata, 1'b1);
      // R3: read is combinational, same cycle as select
      drive(1, 0, 1, 3'd7, 0, 0, 1, 3'd0);
      #1;
      check("R3 same-cycle read", l_rdata, 1'b0);

      // R10: standby combinations
      drive(0, 0, 1, 0, 0, 0, 1, 0);
      l_mem_en = 0; r_mem_en = 1; #1;
      check("R10 left idle", l_standby, 1'b1);
      check("R10 right mem", r_standby, 1'b0);
      l_mem_en = 0; l_sem_sel = 1; r_mem_en = 0; #1;
      check("R10 left sel", l_standby, 1'b0);
      check("R10 right idle", r_standby, 1'b1);
      l_mem_en = 1; l_sem_sel = 0; #1;
      check("R10 left mem", l_standby, 1'b0);
      l_mem_en = 0; r_mem_en = 0;

      // R1: reset clears holders and pending requests
      drive(1, 1, 0, 3'd3, 0, 0, 1, 0);     // L holds 3
      drive(0, 0, 1, 0, 1, 1, 0, 3'd3);     // R pending on 3
      drive(0, 0, 1, 0, 0, 0, 1, 0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      read_all_free("R1 after reset");
      drive(1, 1, 0, 3'd3, 0, 0, 1, 0);     // L takes 3
      read_both(3'd3, "R1", 1'b0, 1'b1);
      drive(1, 1, 1, 3'd3, 0, 0, 1, 0);     // L releases; no stale pending
      read_both(3'd3, "R1 pending cleared", 1'b1, 1'b1);

      // R6 mirror: right request alone on free flag 4
      drive(0, 0, 1, 0, 1, 1, 0, 3'd4);
      read_both(3'd4, "R2 right", 1'b1, 1'b0);

      drive(0, 0, 1, 0, 0, 0, 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule